// File: doc/BRIEF.md
# Nonvolatile Memory Command Launch and Status Register

This block is the software-facing status register and start interlock that sits in front of a nonvolatile memory command engine. One 8-bit register carries a command-complete flag, an access-error flag, a protection-violation flag, a busy indicator and a two-bit completion code. Software starts a command by writing a one to the complete flag. That write clears the flag and sends a single-cycle start pulse to the engine. The flag comes back only when the engine signals done, or when a sequence violation cuts the command short.

The two error flags are sticky. Violation inputs from the engine set them, and only a write of one to the flag's own bit clears them. While either error flag is set, no command can be started. The completion code is cleared at each start. It is loaded from the engine's error code on the done handshake, and error codes reported by the reset sequence are ORed into it. All control and status pins are plain level or pulse signals. Writes are a single-cycle strobe with an address, and no part of the interface uses back-pressure. The read data is combinational from the held state.

Top module: `nvm_launch_stat`

## Requirements
- R1: After reset the read value is 0x80. The complete flag (bit 7) is 1, every other bit is 0, and the start pulse is low.
- R2: A write hitting REG_ADDR with data bit 7 = 1, while the complete flag is 1 and both error flags are 0, clears the complete flag and raises `eng_start` for exactly one cycle, starting on the clock edge after the write.
- R3: While the complete flag is 0, further writes of 1 to bit 7 produce no additional start pulse.
- R4: `eng_done` while the complete flag is 0 sets the complete flag and loads `eng_err_code` into bits 1:0.
- R5: A start clears bits 1:0 to 0.
- R6: `seq_viol` sets the access-error flag (bit 5). While this flag is 1, a write of 1 to bit 7 starts nothing. The flag clears only on a write with bit 5 = 1, and a write of 0 to bit 5 leaves it unchanged.
- R7: `prot_viol` sets the protection-violation flag (bit 4). This flag blocks starts and clears in the same way as the access-error flag, through bit 4.
- R8: If a violation input and a clearing write for the same flag occur in the same cycle, the flag is 1 afterwards.
- R9: Bit 3 reads `eng_busy` while the complete flag is 0, and reads 0 while the complete flag is 1.
- R10: `seq_viol` while a command is running (complete flag 0) returns the complete flag to 1.
- R11: Bits 6 and 2 always read 0. Bits 1:0 cannot be written by software. Writes to any address other than REG_ADDR change nothing.
- R12: `init_err_vld` ORs `init_err_code` into bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register value |
| eng_start | output | 1 | One-cycle command start pulse to the engine |
| eng_busy | input | 1 | Engine is executing a command |
| eng_done | input | 1 | Engine finished the command (pulse) |
| eng_err_code | input | ST_W | Engine completion code, valid with eng_done |
| seq_viol | input | 1 | Command sequence violation (pulse) |
| prot_viol | input | 1 | Protection violation (pulse) |
| init_err_vld | input | 1 | Reset-sequence error report (pulse) |
| init_err_code | input | ST_W | Reset-sequence error code |

## Verification
Every piece of state in the block is visible in `rd_data` one edge after the event that changes it. A wrong flag value therefore shows up at the very next read. Starts are the exception: a start that should not have happened, or a missing one, appears on `eng_start` in the cycle right after the write. The check after each vector covers both. A flag stuck high shows as a start that never fires. A wrong priority between setting and clearing a flag shows as a bit that is still clear after a same-cycle collision.

// File: rtl/nvm_stat_pkg.sv
package nvm_stat_pkg;
  localparam int BIT_DONE  = 7;
  localparam int BIT_ACC   = 5;
  localparam int BIT_PROT  = 4;
  localparam int BIT_BUSY  = 3;
  localparam int N_STICKY  = 2;
  localparam int IDX_ACC   = 0;
  localparam int IDX_PROT  = 1;
endpackage

// File: rtl/nvm_sticky_flag.sv
module nvm_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  // R6 R7 R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  // R6 R7
  sticky_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(clr_i));
endmodule

// File: rtl/nvm_launch_ctl.sv
module nvm_launch_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic done_i,
  input  logic abort_i,
  output logic idle_q,
  output logic start_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= 1'b1;
      start_q <= 1'b0;
    end else begin
      start_q <= go_i;
      if (go_i)                              idle_q <= 1'b0;
      else if (!idle_q && (done_i || abort_i)) idle_q <= 1'b1;
    end
  end

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  // R2
  start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> !idle_q);
  // R4 R10
  done_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_q && (done_i || abort_i)) |=> idle_q);
endmodule

// File: rtl/nvm_status_field.sv
module nvm_status_field #(
  parameter int ST_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            load_i,
  input  logic [ST_W-1:0] load_code_i,
  input  logic            or_i,
  input  logic [ST_W-1:0] or_code_i,
  output logic [ST_W-1:0] code_q
);
  logic [ST_W-1:0] base_d;
  logic [ST_W-1:0] code_d;

  always_comb begin
    if (clear_i)     base_d = '0;
    else if (load_i) base_d = load_code_i;
    else             base_d = code_q;
    code_d = base_d | (or_i ? or_code_i : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  // R5
  clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !or_i) |=> (code_q == '0));
  // R12
  init_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    or_i |=> ((code_q & $past(or_code_i)) == $past(or_code_i)));
endmodule

// File: rtl/nvm_launch_stat.sv
module nvm_launch_stat
  import nvm_stat_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter int              ST_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              eng_start,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic [ST_W-1:0]   eng_err_code,
  input  logic              seq_viol,
  input  logic              prot_viol,
  input  logic              init_err_vld,
  input  logic [ST_W-1:0]   init_err_code
);
  logic                wr_hit;
  logic                go;
  logic                idle_q;
  logic                blocked;
  logic [ST_W-1:0]     code_q;
  logic [N_STICKY-1:0] flag_set;
  logic [N_STICKY-1:0] flag_clr;
  logic [N_STICKY-1:0] flag_q;
  logic                unused_wr_bits;

  assign wr_hit  = wr_en && (wr_addr == REG_ADDR);
  assign blocked = |flag_q;
  assign go      = wr_hit && wr_data[BIT_DONE] && idle_q && !blocked;
  assign unused_wr_bits = ^{wr_data[6], wr_data[3:0]};

  assign flag_set[IDX_ACC]  = seq_viol;
  assign flag_set[IDX_PROT] = prot_viol;
  assign flag_clr[IDX_ACC]  = wr_hit && wr_data[BIT_ACC];
  assign flag_clr[IDX_PROT] = wr_hit && wr_data[BIT_PROT];

  for (genvar g = 0; g < N_STICKY; g++) begin : g_flag
    nvm_sticky_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (flag_set[g]),
      .clr_i  (flag_clr[g]),
      .flag_q (flag_q[g])
    );
  end

  nvm_launch_ctl u_launch (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (go),
    .done_i  (eng_done),
    .abort_i (seq_viol),
    .idle_q  (idle_q),
    .start_q (eng_start)
  );

  nvm_status_field #(.ST_W(ST_W)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (go),
    .load_i      (eng_done && !idle_q),
    .load_code_i (eng_err_code),
    .or_i        (init_err_vld),
    .or_code_i   (init_err_code),
    .code_q      (code_q)
  );

  always_comb begin
    rd_data            = '0;
    rd_data[BIT_DONE]  = idle_q;
    rd_data[BIT_ACC]   = flag_q[IDX_ACC];
    rd_data[BIT_PROT]  = flag_q[IDX_PROT];
    rd_data[BIT_BUSY]  = eng_busy && !idle_q;
    rd_data[ST_W-1:0]  = code_q;
  end

  // R6 R7
  start_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_data[BIT_DONE] && blocked) |=> !eng_start);
  // R3
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_q) |=> !eng_start);
endmodule

// File: tb/tb_nvm_launch_stat.sv
module tb_nvm_launch_stat;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       wr;
    logic [3:0] addr;
    logic [7:0] wd;
    logic       sv;
    logic       pv;
    logic       dn;
    logic       bz;
    logic [1:0] er;
    logic [7:0] rd;
    logic       st;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'h0, 8'h00, 1'b0,1'b0,1'b0,1'b0, 2'd0, 8'h80, 1'b0, 4'd1},  // R1 idle
    '{1'b1, 4'h0, 8'h80, 1'b0,1'b0,1'b0,1'b0, 2'd0, 8'h00, 1'b1, 4'd2},  // R2 start
    '{1'b0, 4'h0, 8'h00, 1'b0,1'b0,1'b0,1'b1, 2'd0, 8'h08, 1'b0, 4'd9},  // R9 busy, pulse gone
    '{1'b1, 4'h0, 8'h80, 1'b0,1'b0,1'b0,1'b1, 2'd0, 8'h08, 1'b0, 4'd3},  // R3 no restart
    '{1'b0, 4'h0, 8'h00, 1'b0,1'b0,1'b1,1'b0, 2'd2, 8'h82, 1'b0, 4'd4},  // R4 done code 2
    '{1'b1, 4'h3, 8'h80, 1'b0,1'b0,1'b0,1'b0, 2'd0, 8'h82, 1'b0, 4'd11}, // R11 other addr
    '{1'b0, 4'h0, 8'h00, 1'b1,1'b0,1'b0,1'b0, 2'd0, 8'hA2, 1'b0, 4'd6},  // R6 set
    '{1'b1, 4'h0, 8'h80, 1'b0,1'b0,1'b0,1'b0, 2'd0, 8'hA2, 1'b0, 4'd6},  // R6 blocked
    '{1'b1, 4'h0, 8'h00, 1'b0,1'b0,1'b0,1'b0, 2'd0, 8'hA2, 1'b0, 4'd6},  // R6 write 0
    '{1'b1, 4'h0, 8'h20, 1'b0,1'b0,1'b0,1'b0, 2'd0, 8'h82, 1'b0, 4'd6},  // R6 clear
    '{1'b0, 4'h0, 8'h00, 1'b0,1'b1,1'b0,1'b0, 2'd0, 8'h92, 1'b0, 4'd7},  // R7 set
    '{1'b1, 4'h0, 8'h80, 1'b0,1'b0,1'b0,1'b0, 2'd0, 8'h92, 1'b0, 4'd7},  // R7 blocked
    '{1'b1, 4'h0, 8'h10, 1'b0,1'b1,1'b0,1'b0, 2'd0, 8'h92, 1'b0, 4'd8},  // R8 set wins
    '{1'b1, 4'h0, 8'h10, 1'b0,1'b0,1'b0,1'b0, 2'd0, 8'h82, 1'b0, 4'd7},  // R7 clear
    '{1'b1, 4'h0, 8'h80, 1'b0,1'b0,1'b0,1'b0, 2'd0, 8'h00, 1'b1, 4'd5},  // R5 start clears code
    '{1'b0, 4'h0, 8'h00, 1'b1,1'b0,1'b0,1'b1, 2'd0, 8'hA0, 1'b0, 4'd10}, // R10 abort
    '{1'b1, 4'h0, 8'h20, 1'b0,1'b0,1'b0,1'b0, 2'd0, 8'h80, 1'b0, 4'd6},  // R6 clear
    '{1'b1, 4'h0, 8'hFF, 1'b0,1'b0,1'b0,1'b0, 2'd0, 8'h00, 1'b1, 4'd11}, // R11 bits 6,2 ignored
    '{1'b0, 4'h0, 8'h00, 1'b0,1'b0,1'b1,1'b0, 2'd1, 8'h81, 1'b0, 4'd4},  // R4 done code 1
    '{1'b1, 4'h0, 8'h45, 1'b0,1'b0,1'b0,1'b0, 2'd0, 8'h81, 1'b0, 4'd11}  // R11 code not writable
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       eng_start;
  logic       eng_busy = 1'b0;
  logic       eng_done = 1'b0;
  logic [1:0] eng_err_code = '0;
  logic       seq_viol = 1'b0;
  logic       prot_viol = 1'b0;
  logic       init_err_vld = 1'b0;
  logic [1:0] init_err_code = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_launch_stat dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_data(rd_data), .eng_start(eng_start),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_err_code(eng_err_code),
    .seq_viol(seq_viol), .prot_viol(prot_viol),
    .init_err_vld(init_err_vld), .init_err_code(init_err_code)
  );

  task automatic check(input int req, input logic [7:0] exp_rd, input logic exp_st);
    checks++;
    if (rd_data !== exp_rd || eng_start !== exp_st) begin
      errors++;
      $display("FAIL R%0d: rd_data=%02h start=%0b expected rd_data=%02h start=%0b",
               req, rd_data, eng_start, exp_rd, exp_st);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check(1, 8'h80, 1'b0);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = VECS[i].wr; wr_addr = VECS[i].addr; wr_data = VECS[i].wd;
      seq_viol = VECS[i].sv; prot_viol = VECS[i].pv; eng_done = VECS[i].dn;
      eng_busy = VECS[i].bz; eng_err_code = VECS[i].er;
      @(posedge clk);
      #1;
      check(int'(VECS[i].req), VECS[i].rd, VECS[i].st);
    end
    @(negedge clk);
    wr_en = 1'b0; seq_viol = 1'b0; prot_viol = 1'b0; eng_done = 1'b0; eng_busy = 1'b0;

    // R12 reset-sequence error ORs into code
    do_reset();
    check(1, 8'h80, 1'b0);
    init_err_vld = 1'b1; init_err_code = 2'd2;
    @(posedge clk); #1;
    check(12, 8'h82, 1'b0);
    @(negedge clk);
    init_err_code = 2'd1;
    @(posedge clk); #1;
    check(12, 8'h83, 1'b0);
    @(negedge clk);
    init_err_vld = 1'b0;

    // R9 busy reads 0 while complete flag is 1
    eng_busy = 1'b1;
    #1;
    check(9, 8'h83, 1'b0);
    @(negedge clk);
    eng_busy = 1'b0;

    // R2 pulse is exactly one cycle: start then observe two following cycles
    wr_en = 1'b1; wr_addr = 4'h0; wr_data = 8'h80;
    @(posedge clk); #1;
    check(2, 8'h00, 1'b1);
    @(negedge clk);
    wr_en = 1'b0;
    @(posedge clk); #1;
    check(2, 8'h00, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule